// File: doc/BRIEF.md
# Time-code sequence filter

This block sits behind the character decoder of a serial link and watches the stream of time codes it delivers. Each code arrives as one 8-bit value with a one-cycle valid strobe. The block keeps the most recently stored count and its two flag bits, and it decides whether each new code is a legitimate time advance. Only a legitimate advance produces a tick.

A code that repeats the stored count is dropped with no effect. Such repeats appear when the network contains loops. A code that jumps to some unrelated count is taken as the new reference, but it produces no tick. Ticks return as soon as a code arrives that is exactly one above the new reference. After reset the block has no reference yet, so it adopts the first code it receives without producing a tick.

A build parameter can silence the tick output entirely. Count and flag capture are unaffected by it.

Top module: `tcode_seq_filter`

## Requirements
- R1: The code input carries the count in bits [5:0] and the flags in bits [7:6]. `count_o` and `flags_o` always show the last stored code. In a cycle with no strobe, neither output changes and `tick_o` stays 0.
- R2: After reset, `count_o` and `flags_o` are 0, `tick_o` is 0, and the filter has no reference.
- R3: The first strobed code after reset is stored with its flags and gives no tick, whatever its value (0 and 1 included).
- R4: Once a reference exists, a code whose count equals the stored count plus one (modulo 64) is stored with its flags. `tick_o` is then 1 for the single cycle that follows the clock edge that sampled the strobe.
- R5: The plus-one test wraps: stored 63 followed by count 0 is a successor and ticks.
- R6: A code whose count equals the stored count is ignored completely. Count and flags are unchanged, even when the incoming flags differ, and no tick is produced.
- R7: Any other count is stored with its flags and gives no tick. A later code equal to that new count plus one ticks again.
- R8: `tick_o` is high only in the cycle after a strobed successor. Successors strobed on consecutive cycles give a tick in each following cycle.
- R9: With `TICK_EN` = 0, `tick_o` is constantly 0. Count and flag capture behave exactly as with `TICK_EN` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| code_vld | input | 1 | Strobe: `code_in` holds a time code this cycle |
| code_in | input | 8 | Time code: flags in [7:6], count in [5:0] |
| count_o | output | 6 | Last stored count |
| flags_o | output | 2 | Flags of the last stored code |
| tick_o | output | 1 | One-cycle pulse for an accepted successor |

## Verification
The main sweep visits every pair of stored count and incoming count: 64 × 64 combinations. Each pair falls into exactly one of three classes: repeat, successor or jump. The classification is therefore tested at every boundary, including the wrap from 63 to 0, and across changing flag values that reveal whether a repeat wrongly overwrote the flags.

Separate patterns cover the following cases:
- The first code after reset, with values 0 and 1. These separate the no-reference case from the repeat and successor cases.
- A run of successors strobed back to back. This tells a one-cycle tick per code apart from a stretched or merged pulse.
- Idle cycles. These show that nothing moves without a strobe.

A second instance built with the tick disabled gets the same stimulus. It must capture identically and never pulse.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
   // Outcome of comparing an incoming count against the stored reference
   typedef enum logic [1:0] {
      VERD_FIRST = 2'd0,  // no reference yet: adopt, no tick
      VERD_NEXT  = 2'd1,  // stored + 1: adopt, tick
      VERD_DUP   = 2'd2,  // equal to stored: drop
      VERD_JUMP  = 2'd3   // anything else: adopt, no tick
   } verdict_e;
endpackage

// File: rtl/tcs_classify.sv
module tcs_classify
   import tcs_pkg::*;
#(
   parameter int CNT_W = 6
) (
   input  logic             synced,
   input  logic [CNT_W-1:0] stored,
   input  logic [CNT_W-1:0] incoming,
   output verdict_e         verdict
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] successor;

   // Modulo 2**CNT_W increment: the carry out is simply dropped
   assign successor = stored + ONE;

   always_comb begin
      if (!synced)                    verdict = VERD_FIRST;
      else if (incoming == stored)    verdict = VERD_DUP;
      else if (incoming == successor) verdict = VERD_NEXT;
      else                            verdict = VERD_JUMP;
   end
endmodule

// File: rtl/tcs_store.sv
module tcs_store
   import tcs_pkg::*;
#(
   parameter int CNT_W  = 6,
   parameter int FLAG_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld,
   input  verdict_e          verdict,
   input  logic [CNT_W-1:0]  cnt_in,
   input  logic [FLAG_W-1:0] flg_in,
   output logic [CNT_W-1:0]  cnt_q,
   output logic [FLAG_W-1:0] flg_q,
   output logic              synced_q
);
   logic take;

   // Every verdict except a repeat replaces the reference
   assign take = vld && (verdict != VERD_DUP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         flg_q    <= '0;
         synced_q <= 1'b0;
      end else if (take) begin
         cnt_q    <= cnt_in;
         flg_q    <= flg_in;
         synced_q <= 1'b1;
      end
   end
endmodule

// File: rtl/tcs_tick.sv
module tcs_tick #(
   parameter bit TICK_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic tick_q
);
   generate
      if (TICK_EN) begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tick_q <= 1'b0;
            else        tick_q <= fire;
         end
      end else begin : g_quiet
         // Register kept so the output timing is identical; the value is tied low
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tick_q <= 1'b0;
            else        tick_q <= fire & 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/tcode_seq_filter.sv
module tcode_seq_filter
   import tcs_pkg::*;
#(
   parameter int CNT_W   = 6,
   parameter int FLAG_W  = 2,
   parameter bit TICK_EN = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      code_vld,
   input  logic [CNT_W+FLAG_W-1:0]   code_in,
   output logic [CNT_W-1:0]          count_o,
   output logic [FLAG_W-1:0]         flags_o,
   output logic                      tick_o
);
   localparam int CODE_W = CNT_W + FLAG_W;

   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
         $error("tcode_seq_filter: CNT_W must lie in 2..16");
      end
      if (FLAG_W < 1 || FLAG_W > 8) begin : g_bad_flag
         $error("tcode_seq_filter: FLAG_W must lie in 1..8");
      end
   endgenerate

   logic [CNT_W-1:0]  in_cnt;
   logic [FLAG_W-1:0] in_flg;
   logic              synced;
   verdict_e          verdict;
   logic              fire;

   // Count in the low bits, flags in the high bits
   assign in_cnt = code_in[CNT_W-1:0];
   assign in_flg = code_in[CODE_W-1:CNT_W];

   tcs_classify #(.CNT_W(CNT_W)) u_classify (
      .synced   (synced),
      .stored   (count_o),
      .incoming (in_cnt),
      .verdict  (verdict)
   );

   tcs_store #(.CNT_W(CNT_W), .FLAG_W(FLAG_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .vld      (code_vld),
      .verdict  (verdict),
      .cnt_in   (in_cnt),
      .flg_in   (in_flg),
      .cnt_q    (count_o),
      .flg_q    (flags_o),
      .synced_q (synced)
   );

   assign fire = code_vld && (verdict == VERD_NEXT);

   tcs_tick #(.TICK_EN(TICK_EN)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (fire),
      .tick_q (tick_o)
   );
endmodule

// File: rtl/tcs_checker.sv
module tcs_checker #(
   parameter int CNT_W   = 6,
   parameter int FLAG_W  = 2,
   parameter bit TICK_EN = 1'b1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    code_vld,
   input logic [CNT_W+FLAG_W-1:0] code_in,
   input logic [CNT_W-1:0]        count_o,
   input logic [FLAG_W-1:0]       flags_o,
   input logic                    tick_o,
   input logic                    synced
);
   logic [CNT_W-1:0]  cin;
   logic [FLAG_W-1:0] fin;
   logic [CNT_W-1:0]  succ;

   assign cin  = code_in[CNT_W-1:0];
   assign fin  = code_in[CNT_W+FLAG_W-1:CNT_W];
   assign succ = count_o + CNT_W'(1);

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !code_vld |=> $stable(count_o) && $stable(flags_o) && !tick_o); // R1

   AST_FIRST_ADOPT: assert property (@(posedge clk) disable iff (!rst_n)
      code_vld && !synced |=> count_o == $past(cin) && flags_o == $past(fin) && !tick_o); // R3

   AST_DUP_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      code_vld && synced && cin == count_o |=> $stable(count_o) && $stable(flags_o) && !tick_o); // R6

   AST_JUMP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      code_vld && synced && cin != count_o && cin != succ
      |=> count_o == $past(cin) && flags_o == $past(fin) && !tick_o); // R7

   AST_TICK_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |-> $past(code_vld) && $past(synced)); // R8

   generate
      if (TICK_EN) begin : g_live_chk
         AST_NEXT_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
            code_vld && synced && cin == succ |=> tick_o && count_o == $past(cin)); // R4
      end else begin : g_quiet_chk
         AST_NEVER_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
            !tick_o); // R9
      end
   endgenerate
endmodule

bind tcode_seq_filter tcs_checker #(
   .CNT_W(CNT_W), .FLAG_W(FLAG_W), .TICK_EN(TICK_EN)
) u_tcs_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .code_vld (code_vld),
   .code_in  (code_in),
   .count_o  (count_o),
   .flags_o  (flags_o),
   .tick_o   (tick_o),
   .synced   (synced)
);

// File: tb/tb_tcode_seq_filter.sv
module tb_tcode_seq_filter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       code_vld = 1'b0;
   logic [7:0] code_in = '0;
   logic [5:0] count_o, count_q;
   logic [1:0] flags_o, flags_q;
   logic       tick_o, tick_q;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   // Reference model state
   logic [5:0] m_cnt = '0;
   logic [1:0] m_flg = '0;
   bit         m_sync = 1'b0;
   bit         m_tick = 1'b0;

   always #10 clk = ~clk;

   tcode_seq_filter #(.CNT_W(6), .FLAG_W(2), .TICK_EN(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .code_vld(code_vld), .code_in(code_in),
      .count_o(count_o), .flags_o(flags_o), .tick_o(tick_o));

   tcode_seq_filter #(.CNT_W(6), .FLAG_W(2), .TICK_EN(1'b0)) dut_quiet (
      .clk(clk), .rst_n(rst_n), .code_vld(code_vld), .code_in(code_in),
      .count_o(count_q), .flags_o(flags_q), .tick_o(tick_q));

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // Compare both instances against the model; tag chosen by caller
   task automatic compare(input string tag);
      chk({tag, " count"}, {2'b0, count_o}, {2'b0, m_cnt});
      chk({tag, " flags"}, {6'b0, flags_o}, {6'b0, m_flg});
      chk({tag, " tick"},  {7'b0, tick_o},  {7'b0, m_tick});
      chk("R9 quiet count", {2'b0, count_q}, {2'b0, m_cnt});
      chk("R9 quiet flags", {6'b0, flags_q}, {6'b0, m_flg});
      chk("R9 quiet tick",  {7'b0, tick_q},  8'd0);
   endtask

   // Called at a falling edge; strobes one code and samples at the next falling edge
   task automatic put(input logic [7:0] c);
      string tag;
      logic [5:0] cc = c[5:0];
      m_tick = 1'b0;
      if (!m_sync) begin
         tag = "R3 first"; m_cnt = cc; m_flg = c[7:6]; m_sync = 1'b1;
      end else if (cc == m_cnt) begin
         tag = "R6 duplicate";
      end else if (cc == 6'(m_cnt + 6'd1)) begin
         tag = (cc == 6'd0) ? "R5 wrap" : "R4 successor";
         m_cnt = cc; m_flg = c[7:6]; m_tick = 1'b1;
      end else begin
         tag = "R7 jump"; m_cnt = cc; m_flg = c[7:6];
      end
      code_vld = 1'b1;
      code_in  = c;
      @(negedge clk);
      compare(tag);
   endtask

   task automatic idle(input string tag);
      code_vld = 1'b0;
      code_in  = 8'hA5;
      m_tick   = 1'b0;
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      compare("R2 reset");
      rst_n = 1'b1;
      @(negedge clk);
      idle("R1 idle after reset");

      // R3: first code 0 must be adopted, not treated as repeat of reset value
      put(8'hC0);
      idle("R8 tick single cycle");
      put(8'h41);          // successor of 0: ticks (R4)
      idle("R8 tick single cycle");
      put(8'h81);          // R6 repeat with new flags: flags stay 2'b01
      idle("R1 idle");

      // R3 again with value 1 after a fresh reset
      rst_n = 1'b0; m_cnt = '0; m_flg = '0; m_sync = 1'b0; m_tick = 1'b0;
      @(negedge clk);
      compare("R2 reset again");
      rst_n = 1'b1;
      @(negedge clk);
      put(8'h01);

      // R8: back-to-back successors, one tick per code
      for (int k = 2; k < 70; k++) put({2'(k), 6'(k)});
      idle("R8 tick drops after run");

      // R7: jump then resume
      put(8'h28);
      put(8'h29);
      put(8'h29);
      idle("R1 idle");

      // Exhaustive sweep of stored value against incoming value (R4 R5 R6 R7)
      for (int s = 0; s < 64; s++) begin
         for (int d = 0; d < 64; d++) begin
            put({2'(s ^ d), 6'(s)});
            put({2'(s + d), 6'(s + d)});
            idle("R1 idle between pairs");
         end
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule